// File: doc/BRIEF.md
# Local History Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken by looking at that branch's own recent outcomes. A few low bits of the branch address pick one slot in a small per-branch history table. The outcome pattern stored in that slot, and nothing else, then selects one 2-bit saturating counter in a pattern table. The upper bit of that counter is the prediction.

The front end presents an address on the lookup port and reads back a taken or not-taken answer in the same cycle. When the branch resolves, the back end presents the same address and the real outcome on the update port. At the next clock edge, the counter chosen by the history as it stood before this outcome is trained toward the outcome. The outcome is then appended to that branch's history.

By default the history is 10 bits wide, giving a 1K-entry pattern table, and 64 history slots are selected by address bits [7:2]. Setting `HIST_W` to 14 gives the full-size arrangement of 16K counters.

Top module: `lhp_top`

## Requirements
- R1: After reset every history slot holds zero and every counter holds 1 (weakly not taken), so every lookup predicts not taken (`predTaken` = 0).
- R2: The history slot is chosen only by PC bits [IDX_LSB+HIST_IDX_W-1:IDX_LSB] (bits [7:2] by default). All other PC bits have no effect on the prediction or on which slot is trained.
- R3: An update shifts the outcome into the least significant bit of the selected history, with taken = 1 and not taken = 0. Every other bit moves up by one place and the oldest bit is discarded.
- R4: A taken update increments the counter selected by the history from before the update, saturating at 3.
- R5: A not-taken update decrements the counter selected by the history from before the update, saturating at 0.
- R6: The prediction is the counter's MSB: a counter value of 2 or 3 predicts taken, and 0 or 1 predicts not taken.
- R7: A lookup is combinational on the stored state. A lookup in the same cycle as an update sees the state from before that update, and the update is visible from the cycle after its clock edge.
- R8: While `updValid` is low, no history or counter changes, whatever `updPc` and `updTaken` hold.
- R9: The counter is indexed by history alone. Two branches in different slots whose histories are equal share one counter, so training through one changes the other's prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lookPc | input | PC_W | Address of the branch being predicted |
| predTaken | output | 1 | Prediction for `lookPc`: 1 = taken |
| updValid | input | 1 | Update strobe for a resolved branch |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome: 1 = taken |

## Verification
A corrupted history slot does not show up at once. It shows up at the next lookup of that branch, because the prediction then comes from the wrong counter. A corrupted counter shows up at any branch whose history currently selects it, which can be a different branch from the one that was updated. For this reason the bench compares a lookup right after every update, and also compares all 64 slots after each burst of training. It also walks chosen counters through both saturation points and uses history aliasing between slots to expose a counter's value through a second branch.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

  localparam int CTR_W = 2;
  localparam logic [CTR_W-1:0] CTR_RESET = 2'd1;
  localparam logic [CTR_W-1:0] CTR_MAX   = 2'd3;
  localparam logic [CTR_W-1:0] CTR_MIN   = 2'd0;

  typedef struct packed {
    logic             histWr;
    logic             shiftIn;
    logic             ctrWr;
    logic [CTR_W-1:0] ctrNext;
  } lhpStrobe_t;

endpackage

// File: rtl/lhp_ctrl.sv
module lhp_ctrl
  import lhp_pkg::*;
(
  input  logic             updValid,
  input  logic             updTaken,
  input  logic [CTR_W-1:0] updCtrOld,
  output lhpStrobe_t       strobe
);

  logic atTop;
  logic atBottom;

  assign atTop    = (updCtrOld == CTR_MAX);
  assign atBottom = (updCtrOld == CTR_MIN);

  always_comb begin
    strobe.histWr  = updValid;
    strobe.shiftIn = updTaken;
    // saturation: suppress the write instead of computing a clamped value
    strobe.ctrWr   = updValid && (updTaken ? !atTop : !atBottom);
    strobe.ctrNext = updTaken ? (updCtrOld + 2'd1) : (updCtrOld - 2'd1);
  end

endmodule

// File: rtl/lhp_datapath.sv
module lhp_datapath
  import lhp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int IDX_LSB    = 2,
  parameter int HIST_IDX_W = 6,
  parameter int HIST_W     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   lookPc,
  input  logic [PC_W-1:0]   updPc,
  input  lhpStrobe_t        strobe,
  output logic [CTR_W-1:0]  lookCtr,
  output logic [CTR_W-1:0]  updCtrOld
);

  localparam int HIST_ENTRIES = 1 << HIST_IDX_W;
  localparam int CTR_ENTRIES  = 1 << HIST_W;

  logic [HIST_W-1:0] histTbl [HIST_ENTRIES];
  logic [CTR_W-1:0]  ctrTbl  [CTR_ENTRIES];

  logic [HIST_IDX_W-1:0] lookIdx;
  logic [HIST_IDX_W-1:0] updIdx;
  logic [HIST_W-1:0]     lookHist;
  logic [HIST_W-1:0]     updHistOld;
  logic [HIST_W-1:0]     updHistNew;
  logic                  unusedPcBits;

  assign lookIdx  = lookPc[IDX_LSB +: HIST_IDX_W];
  assign updIdx   = updPc[IDX_LSB +: HIST_IDX_W];
  assign unusedPcBits = ^{lookPc, updPc};

  // first level, then second level, both read combinationally
  assign lookHist   = histTbl[lookIdx];
  assign lookCtr    = ctrTbl[lookHist];
  assign updHistOld = histTbl[updIdx];
  assign updCtrOld  = ctrTbl[updHistOld];

  generate
    if (HIST_W > 1) begin : g_shift
      assign updHistNew = {updHistOld[HIST_W-2:0], strobe.shiftIn};
    end else begin : g_single
      assign updHistNew = strobe.shiftIn;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HIST_ENTRIES; i++) histTbl[i] <= '0;
      for (int j = 0; j < CTR_ENTRIES; j++)  ctrTbl[j]  <= CTR_RESET;
    end else begin
      if (strobe.histWr) histTbl[updIdx] <= updHistNew;
      // indexed by the history read before this edge rewrites it
      if (strobe.ctrWr)  ctrTbl[updHistOld] <= strobe.ctrNext;
    end
  end

  // R3: newest outcome lands in bit 0
  a_r3_hist_newest: assert property (@(posedge clk) disable iff (rst)
    strobe.histWr |=> histTbl[$past(updIdx)][0] == $past(strobe.shiftIn));

  generate
    if (HIST_W > 1) begin : g_age_chk
      // R3: older bits age by one place
      a_r3_hist_age: assert property (@(posedge clk) disable iff (rst)
        strobe.histWr |=> histTbl[$past(updIdx)][HIST_W-1:1] == $past(updHistOld[HIST_W-2:0]));
    end
  endgenerate

  // R4: taken below the top climbs by one
  a_r4_ctr_up: assert property (@(posedge clk) disable iff (rst)
    (strobe.histWr && strobe.shiftIn && updCtrOld != CTR_MAX)
      |=> ctrTbl[$past(updHistOld)] == $past(updCtrOld) + 2'd1);

  // R4: taken at the top stays at the top
  a_r4_ctr_sat_hi: assert property (@(posedge clk) disable iff (rst)
    (strobe.histWr && strobe.shiftIn && updCtrOld == CTR_MAX)
      |=> ctrTbl[$past(updHistOld)] == CTR_MAX);

  // R5: not taken above the bottom falls by one
  a_r5_ctr_down: assert property (@(posedge clk) disable iff (rst)
    (strobe.histWr && !strobe.shiftIn && updCtrOld != CTR_MIN)
      |=> ctrTbl[$past(updHistOld)] == $past(updCtrOld) - 2'd1);

  // R5: not taken at the bottom stays at the bottom
  a_r5_ctr_sat_lo: assert property (@(posedge clk) disable iff (rst)
    (strobe.histWr && !strobe.shiftIn && updCtrOld == CTR_MIN)
      |=> ctrTbl[$past(updHistOld)] == CTR_MIN);

endmodule

// File: rtl/lhp_top.sv
module lhp_top
  import lhp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int IDX_LSB    = 2,
  parameter int HIST_IDX_W = 6,
  parameter int HIST_W     = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lookPc,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);

  lhpStrobe_t       strobe;
  logic [CTR_W-1:0] lookCtr;
  logic [CTR_W-1:0] updCtrOld;

  lhp_ctrl u_ctrl (
    .updValid  (updValid),
    .updTaken  (updTaken),
    .updCtrOld (updCtrOld),
    .strobe    (strobe)
  );

  lhp_datapath #(
    .PC_W       (PC_W),
    .IDX_LSB    (IDX_LSB),
    .HIST_IDX_W (HIST_IDX_W),
    .HIST_W     (HIST_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .lookPc    (lookPc),
    .updPc     (updPc),
    .strobe    (strobe),
    .lookCtr   (lookCtr),
    .updCtrOld (updCtrOld)
  );

  assign predTaken = lookCtr[CTR_W-1];

  // R1: leaving reset, nothing predicts taken
  a_r1_reset_not_taken: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !predTaken);

endmodule

// File: tb/lhp_top_bench.sv
`timescale 1ns/1ps
module lhp_top_bench;

  localparam int PC_W = 32;
  localparam int LSB  = 2;
  localparam int IW   = 6;
  localparam int HW   = 4;
  localparam int NE   = 1 << IW;
  localparam int NC   = 1 << HW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] lookPc = '0;
  logic            predTaken;
  logic            updValid = 1'b0;
  logic [PC_W-1:0] updPc = '0;
  logic            updTaken = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [HW-1:0] histM [NE];
  logic [1:0]    ctrM  [NC];

  always #2.5 clk = ~clk;

  lhp_top #(.PC_W(PC_W), .IDX_LSB(LSB), .HIST_IDX_W(IW), .HIST_W(HW)) u_lhp_top (
    .clk(clk), .rst(rst), .lookPc(lookPc), .predTaken(predTaken),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken)
  );

  function automatic logic [PC_W-1:0] mkPc(input int e);
    logic [PC_W-1:0] r;
    r = $urandom();
    r[LSB +: IW] = e[IW-1:0];
    return r;
  endfunction

  function automatic logic modelPred(input int e);
    return ctrM[histM[e]][1];
  endfunction

  task automatic check(input logic got, input logic exp, input string req);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic modelUpdate(input int e, input logic tk);
    logic [HW-1:0] h;
    h = histM[e];
    if (tk && ctrM[h] != 2'd3) ctrM[h] = ctrM[h] + 2'd1;
    if (!tk && ctrM[h] != 2'd0) ctrM[h] = ctrM[h] - 2'd1;
    histM[e] = {h[HW-2:0], tk};
  endtask

  // probe: look up entry p after the update
  task automatic doUpdate(input int e, input logic tk, input int p, input string req);
    logic [PC_W-1:0] pc;
    pc = mkPc(e);
    @(negedge clk);
    updValid = 1'b1; updPc = pc; updTaken = tk; lookPc = pc;
    #1 check(predTaken, modelPred(e), "R7 same-cycle lookup sees old state");
    @(posedge clk);
    modelUpdate(e, tk);
    @(negedge clk);
    updValid = 1'b0;
    lookPc = mkPc(p);
    #1 check(predTaken, modelPred(p), req);
  endtask

  task automatic sweepAll(input string req);
    for (int i = 0; i < NE; i++) begin
      lookPc = mkPc(i);
      #0.2 check(predTaken, modelPred(i), req);
    end
  endtask

  initial begin : watchdog
    #(100000 * 5);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) histM[i] = '0;
    for (int i = 0; i < NC; i++) ctrM[i] = 2'd1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: every slot predicts not taken
    for (int i = 0; i < NE; i++) begin
      lookPc = mkPc(i);
      #0.2 check(predTaken, 1'b0, "R1 reset predicts not taken");
    end

    // R6/R9: slot 1 trains counter 0 which slot 2 (history 0) observes
    doUpdate(1, 1'b1, 2, "R6 counter 2 predicts taken via R9 alias"); // ctr0=2
    doUpdate(3, 1'b1, 2, "R4 climb to 3, R9 alias");                 // ctr0=3
    doUpdate(4, 1'b1, 2, "R4 saturate at 3");                        // ctr0=3
    doUpdate(5, 1'b0, 2, "R4 saturation held, now 2 (R6 taken)");    // ctr0=2
    doUpdate(5, 1'b0, 2, "R6 counter 1 predicts not taken");         // ctr0=1
    doUpdate(5, 1'b0, 2, "R5 fall to 0");                            // ctr0=0
    doUpdate(5, 1'b0, 2, "R5 saturate at 0");                        // ctr0=0
    doUpdate(6, 1'b1, 2, "R5 saturation held, now 1");               // ctr0=1
    doUpdate(7, 1'b1, 2, "R6 counter 2 taken");                      // ctr0=2
    // R3: slot 1 history is 0001; with shifts it reaches 1000 then 0000
    doUpdate(1, 1'b0, 1, "R3 history shift");
    doUpdate(1, 1'b0, 1, "R3 history shift");
    doUpdate(1, 1'b0, 1, "R3 history shift");
    doUpdate(1, 1'b0, 1, "R3 oldest bit dropped, back on counter 0");
    sweepAll("R3 all slots after directed phase");

    // near-exhaustive training sweep over every slot
    for (int e = 0; e < NE; e++) begin
      for (int k = 0; k < 12; k++) begin
        logic tk;
        tk = (((e * 7 + k * 3 + (k * k)) % 5) < 3);
        doUpdate(e, tk, e, tk ? "R4 taken training" : "R5 not-taken training");
      end
      if (e % 8 == 7) sweepAll("R3 slot histories after training");
    end

    // R8: junk on the update port with updValid low
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      updValid = 1'b0; updPc = $urandom(); updTaken = c[0];
    end
    @(negedge clk);
    sweepAll("R8 state unchanged without updValid");

    // R2: other PC bits do not matter
    for (int i = 0; i < 4 * NE; i++) begin
      lookPc = mkPc(i % NE);
      #0.2 check(predTaken, modelPred(i % NE), "R2 index from PC bits only");
    end

    // R2: update through a PC that differs outside the index field
    doUpdate(9, 1'b1, 9, "R2 update index ignores other PC bits");
    doUpdate(9, 1'b1, 9, "R2 update index ignores other PC bits");
    sweepAll("R2 no other slot touched");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule